// File: doc/BRIEF.md
# Serial Save Memory Slave (byte level)

This block models the storage device that sits behind a cartridge's serial save port, at the granularity of whole bytes rather than individual clock edges. A host presents one byte per transfer strobe together with a chip-hold flag. The first held byte after a released hold opens a new command. The bytes that follow carry any address and then exchange data. Every transfer produces one response byte, which the block keeps on its read port until the next transfer.

The device holds a byte array sized by a parameter and an 8-bit status register whose bit 1 is the write-enable latch. The implemented commands are: 0x03 reads the array, 0x06 sets the latch, 0x04 clears it, 0x05 returns the status register, and 0x9F returns an identification byte. The number of address bytes follows from the array size. A read that runs past the last byte returns zero and does not wrap. A separate preload port fills the array so that a test environment can supply save contents.

Top module: `save_mem_slave`

## Requirements
- R1: After reset, the response byte is 0x00, the status register is 0x00, and the stored command is 0x00.
- R2: The command is latched only from a transfer with hold high while the internal hold state is clear. That transfer sets the response to 0x00 and restarts the address and byte position. Later held bytes never replace the command.
- R3: A transfer with hold low still executes the current command for that byte and then clears the internal hold state, so the next held byte opens a new command.
- R4: After command 0x03, the next ADDR_BYTES bytes (2 for arrays of 257 to 65536 bytes) shift into the address most significant byte first, and each returns 0x00.
- R5: After the address phase of 0x03, each transfer returns the array byte at the current address and then advances the address by one.
- R6: A read at an address equal to or above MEM_BYTES returns 0x00.
- R7: Command 0x06 sets status bit 1 and command 0x04 clears it. Each returns 0x00 on the bytes that execute it.
- R8: Command 0x05 returns the current status register on every byte that follows the command byte.
- R9: Command 0x9F returns 0xFF on every byte that follows the command byte.
- R10: Any other command leaves both the response byte and the status register unchanged.
- R11: Without a transfer strobe, the response byte holds the value from the most recent transfer.
- R12: A preload write stores pre_data at pre_addr, and a later 0x03 read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xfer_valid | input | 1 | One transfer on this cycle |
| xfer_hold | input | 1 | Chip-hold flag for this transfer |
| xfer_byte | input | 8 | Byte sent by the host |
| resp_byte | output | 8 | Response byte from the most recent transfer |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | $clog2(MEM_BYTES) | Preload byte address |
| pre_data | input | 8 | Preload byte value |

## Verification
The bench runs reads that cross the last array byte. A design that wraps the address would return byte 0 there, where zero is expected. It also ends each sequence with a byte sent with hold low. A design that drops that byte loses the last read value, and one that keeps the hold state merges two commands. Sending 0x9F with hold high inside a status read catches a design that re-latches the command on every held byte, because it would answer 0xFF instead of the status. A status read issued after an unknown command exposes any design that lets an unknown opcode disturb the write-enable latch.

// File: rtl/save_mem_pkg.sv
package save_mem_pkg;

  localparam logic [7:0] CMD_READ = 8'h03;
  localparam logic [7:0] CMD_WRDI = 8'h04;
  localparam logic [7:0] CMD_RDSR = 8'h05;
  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_RDID = 8'h9F;

  localparam logic [7:0] ID_BYTE = 8'hFF;
  localparam int         WEL_BIT = 1;

  // Address byte count implied by the array size
  function automatic int addr_bytes_for(input int n_bytes);
    if (n_bytes <= 256)   return 1;
    if (n_bytes <= 65536) return 2;
    return 3;
  endfunction

endpackage

// File: rtl/save_mem_rst_sync.sv
module save_mem_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/save_mem_array.sv
module save_mem_array #(
  parameter int DEPTH = 2048,
  parameter int IDX_W = 11,
  parameter int RA_W  = 17
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [RA_W-1:0]  rd_addr,
  output logic [7:0]       rd_data
);

  localparam logic [RA_W-1:0] LIMIT = RA_W'(DEPTH);

  logic [7:0] store [DEPTH];
  logic       in_range;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
  end

  always_comb begin
    in_range = (rd_addr < LIMIT);
    rd_data  = in_range ? store[rd_addr[IDX_W-1:0]] : 8'h00;
  end

endmodule

// File: rtl/save_mem_status.sv
module save_mem_status
  import save_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  output logic [7:0] status_q
);

  logic [7:0] status_d;
  logic       status_en;

  always_comb begin
    status_en = set_wel | clr_wel;
    status_d  = status_q;
    if (set_wel)      status_d[WEL_BIT] = 1'b1;
    else if (clr_wel) status_d[WEL_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= 8'h00;
    else if (status_en) status_q <= status_d;
  end

endmodule

// File: rtl/save_mem_seq.sv
module save_mem_seq
  import save_mem_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int RA_W       = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_valid,
  input  logic            xfer_hold,
  input  logic [7:0]      xfer_byte,
  input  logic [7:0]      mem_rdata,
  input  logic [7:0]      status_q,
  output logic [7:0]      resp_q,
  output logic [7:0]      cmd_q,
  output logic            held_q,
  output logic [RA_W-1:0] addr_q,
  output logic            set_wel,
  output logic            clr_wel
);

  localparam int               POS_W    = $clog2(ADDR_BYTES + 2);
  localparam logic [POS_W-1:0] POS_DATA = POS_W'(ADDR_BYTES + 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [7:0]       resp_d, cmd_d;
  logic             held_d;
  logic [RA_W-1:0]  addr_d;
  logic             start_cmd, run_cmd, seq_en;

  always_comb begin
    start_cmd = xfer_valid & xfer_hold & ~held_q;
    run_cmd   = xfer_valid & ~start_cmd;
    seq_en    = xfer_valid;

    resp_d  = resp_q;
    cmd_d   = cmd_q;
    held_d  = held_q;
    addr_d  = addr_q;
    pos_d   = pos_q;
    set_wel = 1'b0;
    clr_wel = 1'b0;

    if (start_cmd) begin
      cmd_d  = xfer_byte;
      held_d = 1'b1;
      resp_d = 8'h00;
      addr_d = '0;
      pos_d  = POS_W'(1);
    end else if (run_cmd) begin
      held_d = xfer_hold;
      case (cmd_q)
        CMD_READ: begin
          if (pos_q < POS_DATA) begin
            addr_d = {addr_q[RA_W-9:0], xfer_byte};
            resp_d = 8'h00;
            pos_d  = pos_q + 1'b1;
          end else begin
            resp_d = mem_rdata;
            addr_d = addr_q + 1'b1;
          end
        end
        CMD_WRDI: begin
          clr_wel = 1'b1;
          resp_d  = 8'h00;
        end
        CMD_RDSR: resp_d = status_q;
        CMD_WREN: begin
          set_wel = 1'b1;
          resp_d  = 8'h00;
        end
        CMD_RDID: resp_d = ID_BYTE;
        default:  resp_d = resp_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= 8'h00;
      cmd_q  <= 8'h00;
      held_q <= 1'b0;
      addr_q <= '0;
      pos_q  <= '0;
    end else if (seq_en) begin
      resp_q <= resp_d;
      cmd_q  <= cmd_d;
      held_q <= held_d;
      addr_q <= addr_d;
      pos_q  <= pos_d;
    end
  end

endmodule

// File: rtl/save_mem_slave.sv
module save_mem_slave
  import save_mem_pkg::*;
#(
  parameter int MEM_BYTES = 2048,
  localparam int IDX_W    = $clog2(MEM_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_valid,
  input  logic             xfer_hold,
  input  logic [7:0]       xfer_byte,
  output logic [7:0]       resp_byte,
  input  logic             pre_we,
  input  logic [IDX_W-1:0] pre_addr,
  input  logic [7:0]       pre_data
);

  localparam int ADDR_BYTES = addr_bytes_for(MEM_BYTES);
  localparam int RA_W       = ADDR_BYTES * 8 + 1;

  logic            rst_sync_n;
  logic [7:0]      mem_rdata;
  logic [7:0]      stat_q;
  logic [7:0]      seq_cmd;
  logic            seq_held;
  logic [RA_W-1:0] seq_addr;
  logic            wel_set, wel_clr;

  save_mem_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  save_mem_array #(
    .DEPTH (MEM_BYTES),
    .IDX_W (IDX_W),
    .RA_W  (RA_W)
  ) u_array (
    .clk     (clk),
    .wr_en   (pre_we),
    .wr_idx  (pre_addr),
    .wr_data (pre_data),
    .rd_addr (seq_addr),
    .rd_data (mem_rdata)
  );

  save_mem_status u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_wel  (wel_set),
    .clr_wel  (wel_clr),
    .status_q (stat_q)
  );

  save_mem_seq #(
    .ADDR_BYTES (ADDR_BYTES),
    .RA_W       (RA_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .xfer_valid (xfer_valid),
    .xfer_hold  (xfer_hold),
    .xfer_byte  (xfer_byte),
    .mem_rdata  (mem_rdata),
    .status_q   (stat_q),
    .resp_q     (resp_byte),
    .cmd_q      (seq_cmd),
    .held_q     (seq_held),
    .addr_q     (seq_addr),
    .set_wel    (wel_set),
    .clr_wel    (wel_clr)
  );

endmodule

// File: rtl/save_mem_checker.sv
module save_mem_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_valid,
  input logic       xfer_hold,
  input logic [7:0] xfer_byte,
  input logic [7:0] resp_byte,
  input logic       held,
  input logic [7:0] cmd,
  input logic [7:0] status
);

  logic run_cmd, known;

  always_comb begin
    run_cmd = xfer_valid && (held || !xfer_hold);
    known   = (cmd == 8'h03) || (cmd == 8'h04) || (cmd == 8'h05) ||
              (cmd == 8'h06) || (cmd == 8'h9F);
  end

  a_r11_resp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |=> $stable(resp_byte));

  a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_hold && !held) |=> (resp_byte == 8'h00 && held && cmd == $past(xfer_byte)));

  a_r2_keep_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && held) |=> $stable(cmd));

  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_hold) |=> !held);

  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cmd && cmd == 8'h06) |=> (status[1] && resp_byte == 8'h00));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cmd && cmd == 8'h04) |=> (!status[1] && resp_byte == 8'h00));

  a_r8_status: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cmd && cmd == 8'h05) |=> resp_byte == $past(status));

  a_r9_ident: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cmd && cmd == 8'h9F) |=> resp_byte == 8'hFF);

  a_r10_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cmd && !known) |=> ($stable(resp_byte) && $stable(status)));

endmodule

bind save_mem_slave save_mem_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .xfer_valid (xfer_valid),
  .xfer_hold  (xfer_hold),
  .xfer_byte  (xfer_byte),
  .resp_byte  (resp_byte),
  .held       (seq_held),
  .cmd        (seq_cmd),
  .status     (stat_q)
);

// File: tb/test_save_mem_slave.sv
module test_save_mem_slave;

  localparam int CLK_PERIOD = 10;
  localparam int MEM        = 2048;
  localparam int IW         = $clog2(MEM);

  logic          clk;
  logic          rst_n;
  logic          xfer_valid;
  logic          xfer_hold;
  logic [7:0]    xfer_byte;
  logic [7:0]    resp_byte;
  logic          pre_we;
  logic [IW-1:0] pre_addr;
  logic [7:0]    pre_data;

  int    ref_mem [MEM];
  int    m_cmd, m_held, m_resp, m_pos, m_addr, m_st;
  int    checks, fails;
  string cur_req;
  bit    cmp_on, done;

  save_mem_slave #(.MEM_BYTES(MEM)) i_save_mem_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_valid (xfer_valid),
    .xfer_hold  (xfer_hold),
    .xfer_byte  (xfer_byte),
    .resp_byte  (resp_byte),
    .pre_we     (pre_we),
    .pre_addr   (pre_addr),
    .pre_data   (pre_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic int pat(input int i);
    return (i * 37 + 11) & 255;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Reference model compared at every falling edge
  always @(negedge clk) if (cmp_on) check(cur_req, int'(resp_byte), m_resp);

  task automatic model_step(input bit h, input int b);
    if (h && m_held == 0) begin
      m_cmd = b; m_held = 1; m_resp = 0; m_pos = 1; m_addr = 0;
    end else begin
      m_held = h;
      case (m_cmd)
        'h03: begin
          if (m_pos <= 2) begin
            m_addr = (m_addr << 8) | b; m_resp = 0; m_pos++;
          end else begin
            m_resp = (m_addr < MEM) ? ref_mem[m_addr] : 0;
            m_addr++;
          end
        end
        'h04: begin m_st = m_st & ~2; m_resp = 0; end
        'h05: m_resp = m_st;
        'h06: begin m_st = m_st | 2; m_resp = 0; end
        'h9F: m_resp = 'hFF;
        default: ;
      endcase
    end
  endtask

  task automatic xfer(input bit h, input int b);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_hold = h; xfer_byte = 8'(b);
    @(posedge clk);
    #1 model_step(h, b);
  endtask

  // Transfer then check the response against a value from the requirement
  task automatic xchk(input bit h, input int b, input string req, input int exp);
    cur_req = req;
    xfer(h, b);
    check(req, int'(resp_byte), exp);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    xfer_valid = 1'b0; xfer_hold = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic preload(input int a, input int d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = IW'(a); pre_data = 8'(d);
    @(posedge clk);
    #1 ref_mem[a] = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; cmp_on = 1'b0; done = 1'b0; cur_req = "R1";
    m_cmd = 0; m_held = 0; m_resp = 0; m_pos = 0; m_addr = 0; m_st = 0;
    rst_n = 1'b0; xfer_valid = 1'b0; xfer_hold = 1'b0; xfer_byte = 8'h00;
    pre_we = 1'b0; pre_addr = '0; pre_data = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(resp_byte), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    check("R1", int'(resp_byte), 0);

    // R12: preload the array through the side port
    for (int i = 0; i < MEM; i++) begin
      @(negedge clk);
      pre_we = 1'b1; pre_addr = IW'(i); pre_data = 8'(pat(i));
      @(posedge clk);
      #1 ref_mem[i] = pat(i);
    end
    @(negedge clk);
    pre_we = 1'b0;
    cmp_on = 1'b1;

    // R1/R8: status reads 0x00 after reset
    xchk(1, 'h05, "R2", 0);
    xchk(1, 'h00, "R1", 0);
    xchk(0, 'h00, "R8", 0);
    idle(2);

    // R7: set latch, then read it back repeatedly
    xchk(1, 'h06, "R2", 0);
    xchk(0, 'h00, "R7", 0);
    xchk(1, 'h05, "R2", 0);
    xchk(1, 'h00, "R8", 'h02);
    xchk(1, 'h9F, "R2", 'h02);
    xchk(0, 'h00, "R8", 'h02);
    idle(3);

    // R10: unknown command leaves the latch and response alone
    xchk(1, 'h5A, "R2", 0);
    xchk(1, 'h77, "R10", 0);
    xchk(0, 'h33, "R10", 0);
    xchk(1, 'h05, "R2", 0);
    xchk(0, 'h00, "R10", 'h02);

    // R7: clear latch
    xchk(1, 'h04, "R2", 0);
    xchk(0, 'h00, "R7", 0);
    xchk(1, 'h05, "R2", 0);
    xchk(0, 'h00, "R7", 0);
    idle(2);

    // R4/R5/R3: read at 0x0010, last byte with hold low
    xchk(1, 'h03, "R2", 0);
    xchk(1, 'h00, "R4", 0);
    xchk(1, 'h10, "R4", 0);
    xchk(1, 'hFF, "R5", pat(16));
    xchk(1, 'hFF, "R5", pat(17));
    xchk(1, 'hFF, "R5", pat(18));
    xchk(0, 'hFF, "R3", pat(19));
    xchk(1, 'h9F, "R3", 0);
    xchk(0, 'h00, "R9", 'hFF);
    idle(4);

    // R11: response held across idle cycles
    cur_req = "R11";
    check("R11", int'(resp_byte), 'hFF);

    // R6: read across the end of the array
    xchk(1, 'h03, "R2", 0);
    xchk(1, 'h07, "R4", 0);
    xchk(1, 'hFE, "R4", 0);
    xchk(1, 'h00, "R5", pat(MEM - 2));
    xchk(1, 'h00, "R5", pat(MEM - 1));
    xchk(1, 'h00, "R6", 0);
    xchk(0, 'h00, "R6", 0);
    xchk(1, 'h03, "R2", 0);
    xchk(1, 'h12, "R4", 0);
    xchk(1, 'h34, "R4", 0);
    xchk(0, 'h00, "R6", 0);
    idle(2);

    // R12: overwrite one byte and read it back
    preload('h20, 'hA5);
    xchk(1, 'h03, "R2", 0);
    xchk(1, 'h00, "R4", 0);
    xchk(1, 'h20, "R4", 0);
    xchk(1, 'h00, "R12", 'hA5);
    xchk(0, 'h00, "R12", pat('h21));
    idle(3);

    cmp_on = 1'b0;
    finish_run();
  end

endmodule